// File: doc/BRIEF.md
# Camera Link Packet Receiver

This block takes a single byte-wide stream of camera-link packets. The bytes have already been gathered from the serial lanes and put back in order. Each byte comes with a valid qualifier and with start-of-packet and end-of-packet markers. The block reads the four-byte header and uses its single-error-correcting, double-error-detecting code to repair or reject the header. It then sorts the packet by its type code.

Short packets have no payload. They raise one-cycle event pulses for frame start, frame end, line start and line end. Long packets are counted through by their byte-length field. Each payload byte is passed downstream tagged with its virtual channel and type code, and the 16-bit CRC at the end of the packet is checked. Every anomaly gives a one-cycle flag pulse. The three error kinds also feed saturating counters, which a monitoring block can read.

Top module: `cam_pkt_rx`

## Requirements
- R1: Header layout and short packets.
  - The four header bytes come in this order: identifier byte, length low byte, length high byte, protection byte.
  - The identifier holds the virtual channel in bits 7:6 and the type code in bits 5:0.
  - A corrected type code below 0x10 marks a short packet, which has no payload.
  - One cycle after its protection byte is accepted, a short packet pulses exactly one of these outputs: `ev_frame_start` (type 0x00), `ev_frame_end` (0x01), `ev_line_start` (0x02) or `ev_line_end` (0x03).
  - In that same cycle it presents its virtual channel on `ev_vc` and its 16-bit field on `ev_word`.
  - Types 0x04 to 0x0F raise no event.
- R2: Header code.
  - Header bit i (identifier = bits 7:0, length = bits 23:8) is covered by column i. Column i is the i-th smallest 6-bit value (counting from 0) that has three or five bits set.
  - Check bit j is the XOR of all header bits whose column has bit j set. The check bits go in protection bits 5:0.
  - Protection bits 7:6 are ignored.
  - A clean header raises neither header flag.
- R3: A single flipped bit anywhere among the 24 header bits and 6 check bits is corrected. The packet is then handled as if clean, and `hdr_fixed` pulses one cycle after the protection byte.
- R4: Two flipped bits pulse `hdr_dropped` instead. The packet is discarded: it raises no event, passes no payload and produces no CRC result. Later bytes are ignored until the next start-of-packet byte.
- R5: Long packet payload.
  - Each of the length-field bytes after the header is output on `pl_data` with `pl_valid` one cycle after it is accepted.
  - `pl_vc` and `pl_dtype` carry the corrected header fields.
  - `pl_first` marks payload byte 0 and `pl_last` marks the final payload byte.
- R6: CRC footer.
  - The CRC uses the polynomial x^16+x^12+x^5+1 with seed 0xFFFF. Each payload byte is processed LSB first, and there is no final inversion.
  - The two footer bytes arrive low byte first, right after the payload.
  - One cycle after the second footer byte, `long_end` pulses, and `crc_fail` pulses with it when the footer differs from the CRC.
  - A zero-length packet expects a footer of 0xFFFF.
- R7: Counters.
  - `cnt_fixed`, `cnt_dropped` and `cnt_crc` each step by one in the same cycle as the matching `hdr_fixed`, `hdr_dropped` or `crc_fail` pulse.
  - Each holds at 2^CNT_W-1 once it gets there.
- R8: Truncation.
  - A packet is abandoned, and `pkt_abort` pulses one cycle later, in either of these cases:
    - an end-of-packet marker arrives on a byte before the packet's final byte;
    - a start-of-packet byte arrives while a packet is in progress.
  - In the second case the new byte begins a fresh header.
- R9: During and after reset, all pulse outputs are low and all counters are zero.
- R10: Cycles with `in_valid` low are ignored wherever they fall. Bytes that are outside a packet and carry no start marker are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte qualifier |
| in_data | input | 8 | Stream byte |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| ev_frame_start | output | 1 | Frame start event pulse |
| ev_frame_end | output | 1 | Frame end event pulse |
| ev_line_start | output | 1 | Line start event pulse |
| ev_line_end | output | 1 | Line end event pulse |
| ev_vc | output | 2 | Virtual channel of the last short packet |
| ev_word | output | 16 | 16-bit field of the last short packet |
| pl_valid | output | 1 | Payload byte strobe |
| pl_data | output | 8 | Payload byte |
| pl_first | output | 1 | First payload byte of the packet |
| pl_last | output | 1 | Final payload byte of the packet |
| pl_vc | output | 2 | Virtual channel tag |
| pl_dtype | output | 6 | Type code tag |
| long_end | output | 1 | Long packet footer checked |
| crc_fail | output | 1 | Footer mismatch pulse |
| hdr_fixed | output | 1 | Header corrected pulse |
| hdr_dropped | output | 1 | Uncorrectable header pulse |
| pkt_abort | output | 1 | Packet abandoned pulse |
| cnt_fixed | output | CNT_W | Saturating count of corrected headers |
| cnt_dropped | output | CNT_W | Saturating count of dropped headers |
| cnt_crc | output | CNT_W | Saturating count of CRC mismatches |

## Verification
The hardest states to reach are the single-bit and two-bit error states of the header code. They are only reachable by sending headers with protection bytes that are consistent, yet deliberately corrupted, so the bench builds the code from its column rule. It then walks one flipped bit through all 30 protected positions, and two flipped bits through all 435 pairs. The counters are built narrow, so both sweeps drive the counters into saturation. A separate sweep corrupts each footer bit in turn to exercise the CRC counter.

// File: rtl/cam_rx_pkg.sv
package cam_rx_pkg;

   localparam int HDR_W  = 24;
   localparam int ECC_W  = 6;
   localparam int DT_W   = 6;
   localparam int VC_W   = 2;
   localparam int LEN_W  = 16;
   localparam int CRC_W  = 16;
   localparam int NUM_EV = 4;

   localparam logic [DT_W-1:0]  DT_LONG_MIN = 6'h10;
   localparam logic [CRC_W-1:0] CRC_SEED    = 16'hFFFF;
   localparam logic [CRC_W-1:0] CRC_POLY_R  = 16'h8408;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_PAY,
      ST_FT0,
      ST_FT1
   } rx_state_e;

   // column of header bit idx: idx-th smallest 6-bit value of weight 3 or 5
   function automatic logic [ECC_W-1:0] ecc_col(input int idx);
      int n;
      logic [ECC_W-1:0] c;
      logic [ECC_W-1:0] r;
      n = 0;
      r = '0;
      for (int v = 0; v < (1 << ECC_W); v++) begin
         c = ECC_W'(v);
         if ($countones(c) == 3 || $countones(c) == 5) begin
            if (n == idx) r = c;
            n++;
         end
      end
      return r;
   endfunction

   // header bits that feed check bit j
   function automatic logic [HDR_W-1:0] ecc_mask(input int j);
      logic [HDR_W-1:0] m;
      logic [ECC_W-1:0] c;
      m = '0;
      for (int i = 0; i < HDR_W; i++) begin
         c = ecc_col(i);
         m[i] = c[j];
      end
      return m;
   endfunction

endpackage

// File: rtl/cam_hdr_ecc.sv
module cam_hdr_ecc
   import cam_rx_pkg::*;
(
   input  logic [HDR_W-1:0] hdr_in,
   input  logic [ECC_W-1:0] chk_in,
   output logic [HDR_W-1:0] hdr_out,
   output logic             err_fixed,
   output logic             err_fatal
);

   logic [ECC_W-1:0] calc;
   logic [ECC_W-1:0] syn;
   logic [HDR_W-1:0] hit;

   for (genvar j = 0; j < ECC_W; j++) begin : g_par
      localparam logic [HDR_W-1:0] MASK = ecc_mask(j);
      assign calc[j] = ^(hdr_in & MASK);
   end

   assign syn = calc ^ chk_in;

   for (genvar i = 0; i < HDR_W; i++) begin : g_hit
      localparam logic [ECC_W-1:0] COL = ecc_col(i);
      assign hit[i] = (syn == COL);
   end

   assign hdr_out   = hdr_in ^ hit;
   assign err_fixed = (|hit) | $onehot(syn);
   assign err_fatal = (syn != '0) & ~err_fixed;

endmodule

// File: rtl/cam_crc16.sv
module cam_crc16 #(
   parameter int              DATA_W = 8,
   parameter int              CRC_W  = 16,
   parameter logic [CRC_W-1:0] POLY  = 16'h8408
) (
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [DATA_W-1:0] data_in,
   output logic [CRC_W-1:0]  crc_out
);

   logic [CRC_W-1:0] c;
   logic             fb;

   always_comb begin
      c = crc_in;
      for (int b = 0; b < DATA_W; b++) begin
         fb = c[0] ^ data_in[b];
         c  = {1'b0, c[CRC_W-1:1]} ^ (fb ? POLY : '0);
      end
      crc_out = c;
   end

endmodule

// File: rtl/cam_sat_cnt.sv
module cam_sat_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);

   localparam logic [W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    count <= '0;
      else if (inc && count != TOP)  count <= count + 1'b1;
   end

endmodule

// File: rtl/cam_pkt_rx.sv
module cam_pkt_rx
   import cam_rx_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   input  logic             in_sop,
   input  logic             in_eop,
   output logic             ev_frame_start,
   output logic             ev_frame_end,
   output logic             ev_line_start,
   output logic             ev_line_end,
   output logic [1:0]       ev_vc,
   output logic [15:0]      ev_word,
   output logic             pl_valid,
   output logic [7:0]       pl_data,
   output logic             pl_first,
   output logic             pl_last,
   output logic [1:0]       pl_vc,
   output logic [5:0]       pl_dtype,
   output logic             long_end,
   output logic             crc_fail,
   output logic             hdr_fixed,
   output logic             hdr_dropped,
   output logic             pkt_abort,
   output logic [CNT_W-1:0] cnt_fixed,
   output logic [CNT_W-1:0] cnt_dropped,
   output logic [CNT_W-1:0] cnt_crc
);

   localparam int HDR_BYTES = HDR_W / 8;

   rx_state_e        st;
   logic [1:0]       hcnt;
   logic [HDR_W-1:0] hbuf;
   logic [VC_W-1:0]  vc_q;
   logic [DT_W-1:0]  dt_q;
   logic [LEN_W-1:0] left_q;
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_nx;
   logic [7:0]       ft_lo;
   logic             first_q;
   logic [NUM_EV-1:0] ev_q;
   logic [NUM_EV-1:0] ev_hit;

   logic [HDR_W-1:0] fix_hdr;
   logic             err_fixed;
   logic             err_fatal;
   logic [DT_W-1:0]  fix_dt;
   logic [VC_W-1:0]  fix_vc;
   logic [LEN_W-1:0] fix_len;

   logic             take;
   logic             hdr_last;
   logic             inc_fix;
   logic             inc_drop;
   logic             inc_crc;

   cam_hdr_ecc u_ecc (
      .hdr_in    (hbuf),
      .chk_in    (in_data[ECC_W-1:0]),
      .hdr_out   (fix_hdr),
      .err_fixed (err_fixed),
      .err_fatal (err_fatal)
   );

   cam_crc16 #(.DATA_W(8), .CRC_W(CRC_W), .POLY(CRC_POLY_R)) u_crc (
      .crc_in  (crc_q),
      .data_in (in_data),
      .crc_out (crc_nx)
   );

   assign fix_dt  = fix_hdr[DT_W-1:0];
   assign fix_vc  = fix_hdr[7:DT_W];
   assign fix_len = fix_hdr[HDR_W-1:8];

   for (genvar k = 0; k < NUM_EV; k++) begin : g_ev
      assign ev_hit[k] = (fix_dt == DT_W'(k));
   end

   assign take     = in_valid && !in_sop;
   assign hdr_last = take && (st == ST_HDR) && (hcnt == 2'(HDR_BYTES));
   assign inc_fix  = hdr_last && err_fixed;
   assign inc_drop = hdr_last && err_fatal;
   assign inc_crc  = take && (st == ST_FT1) && ({in_data, ft_lo} != crc_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         hcnt        <= '0;
         hbuf        <= '0;
         vc_q        <= '0;
         dt_q        <= '0;
         left_q      <= '0;
         crc_q       <= CRC_SEED;
         ft_lo       <= '0;
         first_q     <= 1'b0;
         ev_q        <= '0;
         ev_vc       <= '0;
         ev_word     <= '0;
         pl_valid    <= 1'b0;
         pl_data     <= '0;
         pl_first    <= 1'b0;
         pl_last     <= 1'b0;
         long_end    <= 1'b0;
         crc_fail    <= 1'b0;
         hdr_fixed   <= 1'b0;
         hdr_dropped <= 1'b0;
         pkt_abort   <= 1'b0;
      end else begin
         ev_q        <= '0;
         pl_valid    <= 1'b0;
         pl_first    <= 1'b0;
         pl_last     <= 1'b0;
         long_end    <= 1'b0;
         crc_fail    <= 1'b0;
         hdr_fixed   <= 1'b0;
         hdr_dropped <= 1'b0;
         pkt_abort   <= 1'b0;
         if (in_valid && in_sop) begin
            pkt_abort  <= (st != ST_IDLE) || in_eop;
            hbuf[7:0]  <= in_data;
            hcnt       <= 2'd1;
            st         <= in_eop ? ST_IDLE : ST_HDR;
         end else if (take) begin
            unique case (st)
               ST_IDLE: ;
               ST_HDR: begin
                  if (hcnt != 2'(HDR_BYTES)) begin
                     hbuf[{hcnt, 3'b000} +: 8] <= in_data;
                     hcnt <= hcnt + 2'd1;
                     if (in_eop) begin
                        pkt_abort <= 1'b1;
                        st        <= ST_IDLE;
                     end
                  end else begin
                     hdr_fixed   <= err_fixed;
                     hdr_dropped <= err_fatal;
                     if (err_fatal) begin
                        st <= ST_IDLE;
                     end else if (fix_dt < DT_LONG_MIN) begin
                        ev_q    <= ev_hit;
                        ev_vc   <= fix_vc;
                        ev_word <= fix_len;
                        st      <= ST_IDLE;
                     end else begin
                        vc_q    <= fix_vc;
                        dt_q    <= fix_dt;
                        left_q  <= fix_len;
                        crc_q   <= CRC_SEED;
                        first_q <= 1'b1;
                        if (in_eop) begin
                           pkt_abort <= 1'b1;
                           st        <= ST_IDLE;
                        end else begin
                           st <= (fix_len == '0) ? ST_FT0 : ST_PAY;
                        end
                     end
                  end
               end
               ST_PAY: begin
                  pl_valid <= 1'b1;
                  pl_data  <= in_data;
                  pl_first <= first_q;
                  pl_last  <= (left_q == LEN_W'(1));
                  first_q  <= 1'b0;
                  crc_q    <= crc_nx;
                  left_q   <= left_q - LEN_W'(1);
                  if (in_eop) begin
                     pkt_abort <= 1'b1;
                     st        <= ST_IDLE;
                  end else if (left_q == LEN_W'(1)) begin
                     st <= ST_FT0;
                  end
               end
               ST_FT0: begin
                  ft_lo <= in_data;
                  if (in_eop) begin
                     pkt_abort <= 1'b1;
                     st        <= ST_IDLE;
                  end else begin
                     st <= ST_FT1;
                  end
               end
               ST_FT1: begin
                  long_end <= 1'b1;
                  crc_fail <= inc_crc;
                  st       <= ST_IDLE;
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   assign ev_frame_start = ev_q[0];
   assign ev_frame_end   = ev_q[1];
   assign ev_line_start  = ev_q[2];
   assign ev_line_end    = ev_q[3];
   assign pl_vc          = vc_q;
   assign pl_dtype       = dt_q;

   cam_sat_cnt #(.W(CNT_W)) u_cnt_fix (
      .clk(clk), .rst_n(rst_n), .inc(inc_fix), .count(cnt_fixed));
   cam_sat_cnt #(.W(CNT_W)) u_cnt_drop (
      .clk(clk), .rst_n(rst_n), .inc(inc_drop), .count(cnt_dropped));
   cam_sat_cnt #(.W(CNT_W)) u_cnt_crc (
      .clk(clk), .rst_n(rst_n), .inc(inc_crc), .count(cnt_crc));

endmodule

// File: rtl/cam_pkt_rx_chk.sv
module cam_pkt_rx_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ev_frame_start,
   input logic             ev_frame_end,
   input logic             ev_line_start,
   input logic             ev_line_end,
   input logic             pl_valid,
   input logic             long_end,
   input logic             crc_fail,
   input logic             hdr_fixed,
   input logic             hdr_dropped,
   input logic             pkt_abort,
   input logic [CNT_W-1:0] cnt_fixed,
   input logic [CNT_W-1:0] cnt_dropped,
   input logic [CNT_W-1:0] cnt_crc
);

   localparam logic [CNT_W-1:0] TOP = '1;

   logic [3:0] evs;
   assign evs = {ev_line_end, ev_line_start, ev_frame_end, ev_frame_start};

   initial begin : cnt_w_chk
      assert (CNT_W >= 2 && CNT_W <= 32)
         else $error("CNT_W must lie in 2..32");
   end

   // R1
   ev_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(evs));

   // R4
   drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_dropped |-> (evs == 4'b0) && !hdr_fixed);

   // R5
   pay_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pl_valid |-> (evs == 4'b0) && !long_end);

   // R6
   crc_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      crc_fail |-> long_end);

   // R8
   abort_no_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_abort |-> !long_end);

   // R7
   fix_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_fixed && $past(cnt_fixed) != TOP) |-> cnt_fixed == $past(cnt_fixed) + 1'b1);

   // R7
   drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_dropped && $past(cnt_dropped) != TOP) |-> cnt_dropped == $past(cnt_dropped) + 1'b1);

   // R7
   crc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_fail && $past(cnt_crc) != TOP) |-> cnt_crc == $past(cnt_crc) + 1'b1);

   // R7
   fix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hdr_fixed |-> $stable(cnt_fixed));

   // R7
   crc_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cnt_crc) == TOP |-> cnt_crc == TOP);

endmodule

bind cam_pkt_rx cam_pkt_rx_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_cam_pkt_rx.sv
`timescale 1ns/1ps
module tb_cam_pkt_rx;

   localparam int CW  = 3;
   localparam int MAX = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [7:0] in_data = '0;
   logic in_sop = 1'b0;
   logic in_eop = 1'b0;
   logic ev_frame_start, ev_frame_end, ev_line_start, ev_line_end;
   logic [1:0] ev_vc;
   logic [15:0] ev_word;
   logic pl_valid, pl_first, pl_last;
   logic [7:0] pl_data;
   logic [1:0] pl_vc;
   logic [5:0] pl_dtype;
   logic long_end, crc_fail, hdr_fixed, hdr_dropped, pkt_abort;
   logic [CW-1:0] cnt_fixed, cnt_dropped, cnt_crc;

   always #2.5 clk = ~clk;

   cam_pkt_rx #(.CNT_W(CW)) dut (.*);

   int n_chk = 0;
   int n_bad = 0;

   int m_fs, m_fe, m_ls, m_le, m_pl, m_first, m_last, m_lend, m_cfail;
   int m_fix, m_drop, m_abort, m_tagerr, m_first_at, m_last_at;
   logic [15:0] m_word;
   logic [1:0]  m_vc;
   logic [7:0]  m_pay [64];
   logic [7:0]  x_pay [64];
   logic [1:0]  x_vc = '0;
   logic [5:0]  x_dt = '0;

   task automatic check(input string req, input longint got, input longint exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic zero_mon();
      m_fs = 0; m_fe = 0; m_ls = 0; m_le = 0; m_pl = 0; m_first = 0; m_last = 0;
      m_lend = 0; m_cfail = 0; m_fix = 0; m_drop = 0; m_abort = 0; m_tagerr = 0;
      m_first_at = -1; m_last_at = -1;
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (ev_frame_start) m_fs++;
         if (ev_frame_end)   m_fe++;
         if (ev_line_start)  m_ls++;
         if (ev_line_end)    m_le++;
         if (ev_frame_start | ev_frame_end | ev_line_start | ev_line_end) begin
            m_word = ev_word;
            m_vc   = ev_vc;
         end
         if (pl_valid) begin
            if (pl_first) begin m_first++; m_first_at = m_pl; end
            if (pl_last)  begin m_last++;  m_last_at  = m_pl; end
            if (pl_vc != x_vc || pl_dtype != x_dt) m_tagerr++;
            if (m_pl < 64) m_pay[m_pl] = pl_data;
            m_pl++;
         end
         if (long_end)    m_lend++;
         if (crc_fail)    m_cfail++;
         if (hdr_fixed)   m_fix++;
         if (hdr_dropped) m_drop++;
         if (pkt_abort)   m_abort++;
      end
   end

   function automatic logic [5:0] tb_col(input int idx);
      int n = 0;
      logic [5:0] r = '0;
      for (int v = 0; v < 64; v++) begin
         int w = $countones(v[5:0]);
         if (w == 3 || w == 5) begin
            if (n == idx) r = v[5:0];
            n++;
         end
      end
      return r;
   endfunction

   function automatic logic [5:0] tb_par(input logic [23:0] h);
      logic [5:0] p = '0;
      for (int i = 0; i < 24; i++) if (h[i]) p ^= tb_col(i);
      return p;
   endfunction

   function automatic logic [15:0] tb_crc(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r = c;
      for (int b = 0; b < 8; b++) r = (r[0] ^ d[b]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
      return r;
   endfunction

   function automatic int sat(input int n);
      return (n > MAX) ? MAX : n;
   endfunction

   task automatic send_byte(input logic [7:0] d, input logic s, input logic e);
      @(negedge clk);
      in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = 8'h5C;
      end
   endtask

   task automatic flush();
      idle(3);
      #1;
   endtask

   task automatic send_hdr(input logic [1:0] vc, input logic [5:0] dt, input logic [15:0] word,
                           input logic [29:0] flip, input logic [1:0] hi2, input logic eop,
                           input int gap);
      logic [23:0] h;
      logic [29:0] all;
      h   = {word, vc, dt};
      all = {tb_par(h), h} ^ flip;
      send_byte(all[7:0], 1'b1, 1'b0);   if (gap > 0) idle(gap);
      send_byte(all[15:8], 1'b0, 1'b0);  if (gap > 0) idle(gap);
      send_byte(all[23:16], 1'b0, 1'b0); if (gap > 0) idle(gap);
      send_byte({hi2, all[29:24]}, 1'b0, eop);
   endtask

   task automatic send_long(input logic [1:0] vc, input logic [5:0] dt, input int len,
                            input int seed, input logic [29:0] flip, input logic [15:0] cx,
                            input int gap);
      logic [15:0] c = 16'hFFFF;
      x_vc = vc; x_dt = dt;
      send_hdr(vc, dt, 16'(len), flip, 2'b00, 1'b0, 0);
      for (int k = 0; k < len; k++) begin
         logic [7:0] b = 8'(seed + k * 37);
         if (k < 64) x_pay[k] = b;
         c = tb_crc(c, b);
         send_byte(b, 1'b0, 1'b0);
         if (gap > 0) idle(gap);
      end
      c ^= cx;
      send_byte(c[7:0], 1'b0, 1'b0);
      send_byte(c[15:8], 1'b0, 1'b1);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected completion");
      finish_run();
   end

   initial begin
      int cnt;
      zero_mon();
      repeat (3) @(negedge clk);
      #1;
      // R9: outputs held during reset
      check("R9 pulses in reset", {ev_frame_start, ev_frame_end, ev_line_start, ev_line_end,
            pl_valid, long_end, crc_fail, hdr_fixed, hdr_dropped, pkt_abort}, 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); #1;
      check("R9 counters after reset", {cnt_fixed, cnt_dropped, cnt_crc}, 0);
      check("R9 pulses after reset", {ev_frame_start, pl_valid, long_end, pkt_abort}, 0);

      // R1: event timing, one cycle after protection byte
      send_hdr(2'd2, 6'h00, 16'h1234, '0, 2'b00, 1'b1, 0);
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      check("R1 frame start pulse", ev_frame_start, 1);
      check("R1 event vc", ev_vc, 2);
      check("R1 event word", ev_word, 16'h1234);
      @(negedge clk);
      check("R1 pulse lasts one cycle", ev_frame_start, 0);
      flush();

      // R1 R2: sweep of all short types and channels, clean headers
      for (int vc = 0; vc < 4; vc++) begin
         for (int dt = 0; dt < 16; dt++) begin
            logic [15:0] w = 16'(dt * 311 + vc * 17 + 3);
            zero_mon();
            send_hdr(2'(vc), 6'(dt), w, '0, 2'b00, 1'b1, (dt == 5) ? 1 : 0);
            flush();
            check("R1 short event kind", m_fs * 1000 + m_fe * 100 + m_ls * 10 + m_le,
                  (dt == 0) ? 1000 : (dt == 1) ? 100 : (dt == 2) ? 10 : (dt == 3) ? 1 : 0);
            if (dt < 4) check("R1 short word and vc", {m_vc, m_word}, {2'(vc), w});
            check("R1 short has no payload", m_pl + m_lend, 0);
            check("R2 clean header no flags", m_fix + m_drop, 0);
         end
      end

      // R2: protection bits 7:6 ignored
      zero_mon();
      send_hdr(2'd1, 6'h01, 16'h0F0F, '0, 2'b11, 1'b1, 0);
      flush();
      check("R2 ignored top protection bits", m_fe * 10 + m_fix + m_drop, 10);

      // R3 R7: every single-bit error corrected
      for (int b = 0; b < 30; b++) begin
         zero_mon();
         send_hdr(2'd1, 6'h02, 16'hBEEF, 30'(1) << b, 2'b00, 1'b1, 0);
         flush();
         check("R3 single error event", m_ls * 10 + m_fix, 11);
         check("R3 single error word", {m_vc, m_word}, {2'd1, 16'hBEEF});
         check("R7 cnt_fixed", cnt_fixed, sat(b + 1));
      end

      // R4 R7: every two-bit error dropped
      cnt = 0;
      for (int i = 0; i < 30; i++) begin
         for (int j = i + 1; j < 30; j++) begin
            zero_mon();
            send_hdr(2'd0, 6'h00, 16'h3C3C, (30'(1) << i) | (30'(1) << j), 2'b00, 1'b1, 0);
            flush();
            cnt++;
            check("R4 double error dropped", m_fs * 100 + m_drop * 10 + m_fix, 10);
            check("R7 cnt_dropped", cnt_dropped, sat(cnt));
         end
      end

      // R4: dropped long header, following bytes ignored
      zero_mon();
      send_hdr(2'd3, 6'h2A, 16'd4, 30'h3, 2'b00, 1'b0, 0);
      for (int k = 0; k < 6; k++) send_byte(8'(k * 9), 1'b0, 1'b0);
      flush();
      check("R4 dropped long no payload", m_pl + m_lend, 0);

      // R5 R6: long packets of several lengths
      begin
         int lens [7] = '{0, 1, 2, 3, 7, 16, 33};
         for (int t = 0; t < 7; t++) begin
            int mism = 0;
            zero_mon();
            send_long(2'(t), 6'(8'h10 + t * 7), lens[t], t * 13 + 1, '0, 16'h0, t % 2);
            flush();
            for (int k = 0; k < lens[t]; k++) if (m_pay[k] !== x_pay[k]) mism++;
            check("R5 payload count", m_pl, lens[t]);
            check("R5 payload bytes", mism, 0);
            check("R5 tags", m_tagerr, 0);
            check("R5 first marker", m_first * 100 + m_first_at, (lens[t] > 0) ? 100 : -1);
            check("R5 last marker", m_last_at, lens[t] - 1);
            check("R6 footer ok", m_lend * 10 + m_cfail, 10);
         end
      end

      // R3: corrected length field on a long packet
      zero_mon();
      send_long(2'd2, 6'h24, 5, 77, 30'(1) << 8, 16'h0, 0);
      flush();
      check("R3 corrected length payload", m_pl, 5);
      check("R3 corrected long flags", m_fix * 100 + m_lend * 10 + m_cfail, 110);

      // R6 R7: every footer bit corrupted
      for (int b = 0; b < 16; b++) begin
         zero_mon();
         send_long(2'd0, 6'h30, 4, b, '0, 16'(1) << b, 0);
         flush();
         check("R6 crc mismatch", m_lend * 10 + m_cfail, 11);
         check("R7 cnt_crc", cnt_crc, sat(b + 1));
      end

      // R8: end marker inside header
      zero_mon();
      send_byte(8'h00, 1'b1, 1'b0);
      send_byte(8'h11, 1'b0, 1'b1);
      flush();
      check("R8 early end in header", m_abort * 10 + m_fs, 10);

      // R8: new start inside payload
      zero_mon();
      x_vc = 2'd1; x_dt = 6'h1F;
      send_hdr(2'd1, 6'h1F, 16'd6, '0, 2'b00, 1'b0, 0);
      for (int k = 0; k < 3; k++) send_byte(8'(k), 1'b0, 1'b0);
      send_hdr(2'd0, 6'h00, 16'h0001, '0, 2'b00, 1'b1, 0);
      flush();
      check("R8 restart abort", m_abort * 1000 + m_fs * 100 + m_lend * 10 + m_pl, 1103);

      // R8: recovery with full long packet
      zero_mon();
      send_long(2'd3, 6'h3F, 3, 5, '0, 16'h0, 0);
      flush();
      check("R8 recovery", m_abort * 100 + m_lend * 10 + m_cfail, 10);

      // R10: stray bytes and masked start markers
      zero_mon();
      for (int k = 0; k < 8; k++) send_byte(8'(k * 3), 1'b0, 1'b0);
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b1; in_data = 8'h00;
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_data = 8'h01;
      flush();
      check("R10 stray bytes ignored", m_fs + m_fe + m_ls + m_le + m_pl + m_abort + m_drop, 0);

      // R10: gaps inside a header
      zero_mon();
      send_hdr(2'd2, 6'h03, 16'h7777, '0, 2'b00, 1'b1, 2);
      flush();
      check("R10 gapped header event", m_le * 10 + m_abort, 10);

      finish_run();
   end

endmodule